// File: doc/BRIEF.md
# Cache Line Write-Back Buffer

This block sits between a data cache and the external memory port and holds one dirty line that a cache miss has pushed out. When the miss handler evicts a dirty line, the block latches the eight 32-bit words of that line together with its 24-bit physical line address, taken from address bits [28:5]. This frees the memory port for the refill read that the miss actually needs. The held line is then written to memory afterwards, as a burst of single-word beats, whenever no read is asking for the port.

Because the line is waiting in the buffer and has not yet reached memory, a later miss to the same line address must not read memory, since memory still holds stale data. The block compares every miss address against the held line. On a match it blocks the memory read and presents the whole held line on a forwarding output, so the cache can refill from it directly. The draining of the held line carries on as normal.

Only one line can be held at a time. A second eviction that arrives while a line is still held is refused with a stall, and the cache must keep offering it until the buffer has emptied.

Top module: `wbb_top`

## Requirements
- R1: After a synchronous active-high reset, `line_held`, `wr_valid`, `fwd_hit` and `mem_rd_req` are 0, and an offered capture is not stalled.
- R2: A capture offered while the buffer is empty is accepted at the clock edge. In the next cycle `line_held` is 1, `wr_addr` equals the captured line address, `wr_beat` is 0, and `wr_data` is word 0 of the line. Word k of the line is `cap_line[32k+31:32k]`.
- R3: A capture offered while a line is held raises `cap_stall` in that same cycle. The held address and data are left unchanged.
- R4: The held line drains in ascending order of word index. Each beat accepted with `wr_ack` advances `wr_beat` by one, and `wr_data` is always word `wr_beat` of the held line.
- R5: A pending memory read wins over the drain. While `mem_rd_req` is 1, `wr_valid` is 0, and the drain resumes at the same beat once the read request drops.
- R6: While a beat is not acknowledged, `wr_beat` and `wr_data` hold their values.
- R7: `wr_last` is 1 only on beat 7. Acknowledging that beat clears `line_held` at the next edge, and captures are then accepted again.
- R8: A miss request (`rd_req` = 1) whose address equals the held line address raises `fwd_hit`, presents the held line on `fwd_line`, and keeps `mem_rd_req` at 0.
- R9: A miss request to any other address, or any miss request while no line is held, raises `mem_rd_req` with `mem_rd_addr` equal to `rd_addr`, and `fwd_hit` stays 0.
- R10: Reset asserted in the middle of a drain discards the held line. `line_held` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Dirty line offered by the eviction path |
| cap_addr | input | 24 | Physical line address (bits 28:5) of the evicted line |
| cap_line | input | 256 | Eight words of the evicted line, with word 0 in the low bits |
| cap_stall | output | 1 | Offered capture refused; the buffer is full |
| rd_req | input | 1 | Cache miss wants a line |
| rd_addr | input | 24 | Line address of the miss |
| fwd_hit | output | 1 | Miss matches the held line |
| fwd_line | output | 256 | Held line, forwarded for refill |
| mem_rd_req | output | 1 | Refill read request to memory |
| mem_rd_addr | output | 24 | Line address of the refill read |
| wr_valid | output | 1 | Write beat presented to memory |
| wr_addr | output | 24 | Line address of the drained line |
| wr_beat | output | 3 | Index of the current word |
| wr_data | output | 32 | Word being written |
| wr_last | output | 1 | Current beat is the final one |
| wr_ack | input | 1 | Memory accepts the presented beat |
| line_held | output | 1 | A line is waiting to drain |

## Verification
The assertions assume that the eviction path keeps `cap_valid` and its line stable while stalled, and that the miss logic drives `rd_req` and `rd_addr` as plain levels with no other ordering rules. The memory side is assumed to acknowledge only beats that are actually presented. The bench changes every input just after a rising edge and keeps `wr_ack` high only while a drain is expected. A miss that interrupts the drain is dropped again after one cycle, so the resumed beat index can be predicted.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  // Line address comparison against the held entry
  function automatic logic line_match(input logic held, input logic [23:0] a,
                                      input logic [23:0] b);
    return held && (a == b);
  endfunction

  // True when beat index is the final beat of a line of the given length
  function automatic logic beat_final(input int unsigned beat,
                                      input int unsigned beats);
    return beat == beats - 1;
  endfunction
endpackage

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int WORD_W = 32,
  parameter int BEATS  = 8,
  parameter int ADDR_W = 24,
  localparam int LINE_W = WORD_W * BEATS,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LINE_W-1:0] in_line,
  input  logic              beat_fire,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr,
  output logic [LINE_W-1:0] held_line,
  output logic [BEAT_W-1:0] beat,
  output logic [WORD_W-1:0] beat_word,
  output logic              beat_last
);
  import wbb_pkg::*;

  logic              held_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] beat_q;

  assign beat_last = held_q && beat_final(32'(beat_q), BEATS);
  assign beat_word = line_q[32'(beat_q)*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      beat_q <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      beat_q <= '0;
    end else if (beat_fire) begin
      if (beat_last) begin
        held_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= in_addr;
      line_q <= in_line;
    end
  end

  assign held      = held_q;
  assign held_addr = addr_q;
  assign held_line = line_q;
  assign beat      = beat_q;

  AST_TAKE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    take |-> !held_q); // R3
  AST_CONTENT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (held_q && !take) |=> $stable(addr_q) && $stable(line_q)); // R3
endmodule

// File: rtl/wbb_hazard.sv
module wbb_hazard #(
  parameter int ADDR_W = 24
) (
  input  logic              held,
  input  logic [ADDR_W-1:0] held_addr,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cap_valid,
  output logic              hit,
  output logic              mem_req,
  output logic              drain_ok,
  output logic              take,
  output logic              stall
);
  import wbb_pkg::*;

  assign hit      = rd_req && line_match(held, held_addr, rd_addr);
  assign mem_req  = rd_req && !hit;
  assign drain_ok = held && !mem_req;
  assign take     = cap_valid && !held;
  assign stall    = cap_valid && held;
endmodule

// File: rtl/wbb_top.sv
module wbb_top #(
  parameter int WORD_W = 32,
  parameter int BEATS  = 8,
  parameter int ADDR_W = 24,
  localparam int LINE_W = WORD_W * BEATS,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] cap_line,
  output logic              cap_stall,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              fwd_hit,
  output logic [LINE_W-1:0] fwd_line,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_last,
  input  logic              wr_ack,
  output logic              line_held
);
  // Named internal events for the assertions
  logic              held;
  logic [ADDR_W-1:0] held_addr;
  logic [LINE_W-1:0] held_line;
  logic              take;
  logic              drain_ok;
  logic              beat_fire;
  logic              last_fire;

  wbb_hazard #(.ADDR_W(ADDR_W)) u_hazard (
    .held(held), .held_addr(held_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .cap_valid(cap_valid), .hit(fwd_hit), .mem_req(mem_rd_req),
    .drain_ok(drain_ok), .take(take), .stall(cap_stall)
  );

  assign beat_fire = drain_ok && wr_ack;
  assign last_fire = beat_fire && wr_last;

  wbb_store #(.WORD_W(WORD_W), .BEATS(BEATS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .take(take), .in_addr(cap_addr), .in_line(cap_line),
    .beat_fire(beat_fire), .held(held), .held_addr(held_addr),
    .held_line(held_line), .beat(wr_beat), .beat_word(wr_data),
    .beat_last(wr_last)
  );

  assign wr_valid    = drain_ok;
  assign wr_addr     = held_addr;
  assign fwd_line    = held_line;
  assign mem_rd_addr = rd_addr;
  assign line_held   = held;

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !mem_rd_req); // R5
  AST_HIT_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> line_held); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (line_held && !beat_fire) |=> $stable(wr_beat) && $stable(wr_data)); // R6
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (beat_fire && !wr_last) |=> (wr_beat == $past(wr_beat) + 1'b1)); // R4
  AST_CLEAR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    last_fire |=> !line_held); // R7
  AST_FILL_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    take |=> line_held && (wr_beat == '0)); // R2
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> !line_held); // R10
endmodule

// File: tb/wbb_top_bench.sv
`timescale 1ns/1ps
module wbb_top_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         cap_valid;
  logic [23:0]  cap_addr;
  logic [255:0] cap_line;
  logic         cap_stall;
  logic         rd_req;
  logic [23:0]  rd_addr;
  logic         fwd_hit;
  logic [255:0] fwd_line;
  logic         mem_rd_req;
  logic [23:0]  mem_rd_addr;
  logic         wr_valid;
  logic [23:0]  wr_addr;
  logic [2:0]   wr_beat;
  logic [31:0]  wr_data;
  logic         wr_last;
  logic         wr_ack;
  logic         line_held;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wbb_top u_wbb_top (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_line(cap_line), .cap_stall(cap_stall), .rd_req(rd_req),
    .rd_addr(rd_addr), .fwd_hit(fwd_hit), .fwd_line(fwd_line),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_beat(wr_beat), .wr_data(wr_data),
    .wr_last(wr_last), .wr_ack(wr_ack), .line_held(line_held)
  );

  // Word k of a test line, built from a seed
  function automatic logic [31:0] word_of(input int seed, input int k);
    return 32'(seed * 32'h0101_0000) ^ 32'(k * 32'h0000_1111) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [255:0] line_of(input int seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = word_of(seed, k);
    return l;
  endfunction

  task automatic check(input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  localparam logic [23:0] A = 24'h12_3456;
  // Miss lookup table: {address, expect hit}
  localparam int NV = 5;
  localparam logic [24:0] VEC [NV] = '{
    {A, 1'b1},
    {A ^ 24'h00_0001, 1'b0},
    {A ^ 24'h80_0000, 1'b0},
    {24'h00_0000, 1'b0},
    {A, 1'b1}
  };

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; cap_valid = 0; cap_addr = '0; cap_line = '0;
    rd_req = 0; rd_addr = '0; wr_ack = 0;
    step(); step();
    rst = 0;
    step();
    cap_valid = 1; cap_addr = 24'h55_5555; #1;
    check("R1 held", 256'(line_held), 0);
    check("R1 wr_valid", 256'(wr_valid), 0);
    check("R1 stall", 256'(cap_stall), 0);
    check("R1 hit", 256'(fwd_hit), 0);
    cap_valid = 0;
    // Miss with nothing held goes to memory (R9)
    rd_req = 1; rd_addr = A; #1;
    check("R9 empty miss req", 256'(mem_rd_req), 1);
    check("R9 empty miss hit", 256'(fwd_hit), 0);
    rd_req = 0;

    // R2 capture
    cap_valid = 1; cap_addr = A; cap_line = line_of(1);
    step();
    cap_valid = 0; #1;
    check("R2 held", 256'(line_held), 1);
    check("R2 addr", 256'(wr_addr), 256'(A));
    check("R2 beat", 256'(wr_beat), 0);
    check("R2 data", 256'(wr_data), 256'(word_of(1, 0)));

    // Miss lookup table (R8, R9, R5)
    for (int i = 0; i < NV; i++) begin
      rd_req = 1; rd_addr = VEC[i][24:1]; #1;
      check("R8/R9 hit", 256'(fwd_hit), 256'(VEC[i][0]));
      check("R9 mem req", 256'(mem_rd_req), 256'(!VEC[i][0]));
      check("R5 write yields", 256'(wr_valid), 256'(VEC[i][0]));
      if (VEC[i][0]) check("R8 line", fwd_line, line_of(1));
      else check("R9 addr", 256'(mem_rd_addr), 256'(VEC[i][24:1]));
      step();
    end
    rd_req = 0;

    // R3 capture while full
    cap_valid = 1; cap_addr = 24'h00_0BAD; cap_line = line_of(9); #1;
    check("R3 stall", 256'(cap_stall), 1);
    step();
    cap_valid = 0; #1;
    check("R3 addr kept", 256'(wr_addr), 256'(A));
    check("R3 data kept", 256'(wr_data), 256'(word_of(1, 0)));

    // R6 no ack holds
    step();
    check("R6 beat hold", 256'(wr_beat), 0);

    // Drain R4 / R7 with an interrupting miss at beat 3 (R5)
    wr_ack = 1;
    for (int k = 0; k < 8; k++) begin
      if (k == 3) begin
        rd_req = 1; rd_addr = 24'h00_0777; #1;
        check("R5 blocked", 256'(wr_valid), 0);
        step();
        rd_req = 0; #1;
        check("R5 resume beat", 256'(wr_beat), 3);
      end
      #1;
      check("R4 beat", 256'(wr_beat), 256'(k));
      check("R4 data", 256'(wr_data), 256'(word_of(1, k)));
      check("R7 last", 256'(wr_last), 256'(k == 7));
      step();
    end
    wr_ack = 0; #1;
    check("R7 cleared", 256'(line_held), 0);
    check("R7 no write", 256'(wr_valid), 0);
    cap_valid = 1; cap_addr = 24'h00_0042; cap_line = line_of(2); #1;
    check("R7 accept again", 256'(cap_stall), 0);
    step();
    cap_valid = 0; #1;
    check("R2 second addr", 256'(wr_addr), 256'(24'h00_0042));

    // R10 reset mid drain
    wr_ack = 1; step(); step();
    check("R10 mid beat", 256'(wr_beat), 2);
    rst = 1; step();
    rst = 0; wr_ack = 0; #1;
    check("R10 cleared", 256'(line_held), 0);
    check("R10 wr_valid", 256'(wr_valid), 0);
    rd_req = 1; rd_addr = 24'h00_0042; #1;
    check("R10 no stale hit", 256'(fwd_hit), 0);
    rd_req = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule